// File: doc/BRIEF.md
# CPU Frame Injection Framer

This block moves one frame at a time from a CPU-side byte stream into a word-wide injection queue. A frame request carries the payload length in bytes. If the queue reports itself ready and below its fill watermark, the block opens the frame with a start control write. It then copies a fixed internal header from an external header register file and packs the payload bytes into 32-bit words. Frames shorter than the minimum size are padded with zero words. The block closes the frame with an end control write and follows it with an all-zero placeholder CRC word.

A request that arrives while the queue is not ready, or while its watermark is reached, is refused. The refusal shows as a one-cycle pulse and is counted as a drop. The block also keeps running counts of the frames and payload bytes it sends. A request that arrives while a frame is already being written is ignored.

Top module: `cpu_inject_framer`

## Requirements
- R1: A request made while `q_ready` is 0 or `q_wmark` is 1 (and `busy` is 0) produces a one-cycle `rejected` pulse in the following cycle. It increments `drop_cnt` and causes no control or data write.
- R2: An accepted frame begins with a control write (`ctl_we`) that has `ctl_sof`=1, `ctl_eof`=0, `ctl_vld`=0 and `ctl_gap`=1, in the cycle after the request.
- R3: The next 9 data writes carry `hdr_word` for `hdr_idx` = 0, 1, …, 8, in that order.
- R4: The payload follows as ceil(len/4) data words. Byte k of the frame sits in bits [8*(k%4)+7 : 8*(k%4)] of word k/4 (little-endian), and unused bytes of the last word are zero.
- R5: When fewer than 15 payload words were written, all-zero data words are added until 15 have been written.
- R6: The end control write has `ctl_eof`=1, `ctl_sof`=0 and `ctl_gap`=1. Its `ctl_vld` is 0 when len < 60 and len mod 4 otherwise.
- R7: The data write in the cycle right after the end control write is an all-zero word, and it is the last write of the frame.
- R8: After each completed frame, `tx_frames` grows by 1 and `tx_bytes` grows by the frame's length.
- R9: `busy` is 1 from the cycle after an accepted request until the CRC word has been written. Requests made while `busy` is 1 are ignored, and `pay_ready` is only 1 while `busy` is 1.
- R10: After reset, all counters read 0 and no write strobe, `busy`, `rejected` or `pay_ready` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame request, sampled while idle |
| len | input | LEN_W | Payload length in bytes (at least 1), sampled with `start` |
| q_ready | input | 1 | Queue can take a frame |
| q_wmark | input | 1 | Queue fill watermark reached |
| pay_byte | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte present |
| pay_ready | output | 1 | Payload byte taken this cycle when `pay_valid` is 1 |
| hdr_idx | output | HIDX_W | Header word index being read |
| hdr_word | input | 32 | Header word at `hdr_idx` |
| ctl_we | output | 1 | Control write strobe |
| ctl_sof | output | 1 | Start-of-frame flag of the control write |
| ctl_eof | output | 1 | End-of-frame flag of the control write |
| ctl_vld | output | 2 | Valid bytes in last word |
| ctl_gap | output | GAP_W | Gap size field |
| data_we | output | 1 | Data word write strobe |
| wr_data | output | 32 | Data word |
| busy | output | 1 | Frame in progress |
| rejected | output | 1 | Request refused pulse |
| tx_frames | output | CNT_W | Frames sent |
| tx_bytes | output | CNT_W | Payload bytes sent |
| drop_cnt | output | CNT_W | Frames refused |

## Verification
The assertions assume that `len` is at least 1 whenever a request is accepted. They also assume that the requester keeps `start` low once the request has been taken and never expects payload to be accepted outside a frame. The stimulus only issues non-zero lengths and drops `start` one edge after raising it, except for one deliberate burst while `busy` is high. It offers payload bytes with occasional idle cycles, so the packing path is exercised both with continuous and with stalled input.

// File: rtl/cpu_inject_framer.sv
module cpu_inject_framer #(
  parameter int LEN_W     = 14,
  parameter int CNT_W     = 32,
  parameter int GAP_W     = 4,
  parameter int HDR_WORDS = 9,
  parameter int MIN_BYTES = 60
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [LEN_W-1:0]             len,
  input  logic                         q_ready,
  input  logic                         q_wmark,
  input  logic [7:0]                   pay_byte,
  input  logic                         pay_valid,
  output logic                         pay_ready,
  output logic [$clog2(HDR_WORDS)-1:0] hdr_idx,
  input  logic [31:0]                  hdr_word,
  output logic                         ctl_we,
  output logic                         ctl_sof,
  output logic                         ctl_eof,
  output logic [1:0]                   ctl_vld,
  output logic [GAP_W-1:0]             ctl_gap,
  output logic                         data_we,
  output logic [31:0]                  wr_data,
  output logic                         busy,
  output logic                         rejected,
  output logic [CNT_W-1:0]             tx_frames,
  output logic [CNT_W-1:0]             tx_bytes,
  output logic [CNT_W-1:0]             drop_cnt
);
  localparam int HIDX_W    = $clog2(HDR_WORDS);
  localparam int MIN_WORDS = (MIN_BYTES + 3) / 4;

  typedef enum logic [2:0] {S_IDLE, S_SOF, S_HDR, S_PAY, S_PAD, S_EOF, S_CRC} st_t;
  st_t st;

  logic [LEN_W-1:0] len_q, bcnt, wcnt;
  logic [31:0]      acc, pay_word;
  logic [1:0]       pos;
  logic             take, last, word_done, q_ok;

  assign q_ok      = q_ready && !q_wmark;
  assign busy      = st != S_IDLE;
  assign pay_ready = st == S_PAY;
  assign take      = pay_ready && pay_valid;
  assign pos       = bcnt[1:0];
  assign last      = bcnt + 1'b1 == len_q;
  assign word_done = take && (pos == 2'd3 || last);
  assign pay_word  = acc | ({24'd0, pay_byte} << {pos, 3'b000});

  assign ctl_we  = st == S_SOF || st == S_EOF;
  assign ctl_sof = st == S_SOF;
  assign ctl_eof = st == S_EOF;
  assign ctl_gap = GAP_W'(1);
  assign ctl_vld = (st == S_EOF && len_q >= LEN_W'(MIN_BYTES)) ? len_q[1:0] : 2'd0;

  assign data_we = st == S_HDR || st == S_PAD || st == S_CRC || word_done;
  always_comb begin
    case (st)
      S_HDR:   wr_data = hdr_word;
      S_PAY:   wr_data = pay_word;
      default: wr_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      len_q     <= '0;
      bcnt      <= '0;
      wcnt      <= '0;
      acc       <= '0;
      hdr_idx   <= '0;
      rejected  <= 1'b0;
      tx_frames <= '0;
      tx_bytes  <= '0;
      drop_cnt  <= '0;
    end else begin
      rejected <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (q_ok) begin
            st    <= S_SOF;
            len_q <= len;
            bcnt  <= '0;
            wcnt  <= '0;
            acc   <= '0;
          end else begin
            rejected <= 1'b1;
            drop_cnt <= drop_cnt + 1'b1;
          end
        end
        S_SOF: begin
          st      <= S_HDR;
          hdr_idx <= '0;
        end
        S_HDR: begin
          hdr_idx <= hdr_idx + 1'b1;
          if (hdr_idx == HIDX_W'(HDR_WORDS - 1)) st <= S_PAY;
        end
        S_PAY: if (take) begin
          bcnt <= bcnt + 1'b1;
          acc  <= word_done ? '0 : pay_word;
          if (word_done) wcnt <= wcnt + 1'b1;
          if (last) st <= (wcnt + 1'b1 >= LEN_W'(MIN_WORDS)) ? S_EOF : S_PAD;
        end
        S_PAD: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt + 1'b1 >= LEN_W'(MIN_WORDS)) st <= S_EOF;
        end
        S_EOF: st <= S_CRC;
        S_CRC: begin
          st        <= S_IDLE;
          tx_frames <= tx_frames + 1'b1;
          tx_bytes  <= tx_bytes + CNT_W'(len_q);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cpu_inject_framer_chk.sv
module cpu_inject_framer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        q_ready,
  input logic        q_wmark,
  input logic        busy,
  input logic        rejected,
  input logic        pay_ready,
  input logic        ctl_we,
  input logic        ctl_sof,
  input logic        ctl_eof,
  input logic [1:0]  ctl_vld,
  input logic        data_we,
  input logic [31:0] wr_data
);
  AST_REJ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) rejected |-> !ctl_we && !data_we && !busy); // R1
  AST_REJ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) rejected |-> $past(start && !(q_ready && !q_wmark))); // R1
  AST_SOF_SHAPE: assert property (@(posedge clk) disable iff (!rst_n) ctl_we && ctl_sof |-> !ctl_eof && ctl_vld == 2'd0 && !data_we); // R2
  AST_SOF_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> ctl_we && ctl_sof); // R2
  AST_CRC_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n) ctl_we && ctl_eof |=> data_we && wr_data == 32'd0); // R7
  AST_END_AFTER_CRC: assert property (@(posedge clk) disable iff (!rst_n) ctl_we && ctl_eof |=> ##1 !busy); // R9
  AST_PAY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n) pay_ready |-> busy); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(ctl_we && data_we)); // R4
endmodule

bind cpu_inject_framer cpu_inject_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .q_ready(q_ready), .q_wmark(q_wmark),
  .busy(busy), .rejected(rejected), .pay_ready(pay_ready), .ctl_we(ctl_we),
  .ctl_sof(ctl_sof), .ctl_eof(ctl_eof), .ctl_vld(ctl_vld), .data_we(data_we),
  .wr_data(wr_data)
);

// File: tb/test_cpu_inject_framer.sv
module test_cpu_inject_framer;
  logic        clk = 0, rst_n = 0, start = 0, q_ready = 1, q_wmark = 0;
  logic [13:0] len = '0;
  logic [7:0]  pay_byte = '0;
  logic        pay_valid = 0, pay_ready;
  logic [3:0]  hdr_idx;
  logic [31:0] hdr_word, wr_data;
  logic        ctl_we, ctl_sof, ctl_eof, data_we, busy, rejected;
  logic [1:0]  ctl_vld;
  logic [3:0]  ctl_gap;
  logic [31:0] tx_frames, tx_bytes, drop_cnt;

  int checks = 0, fails = 0;
  logic [35:0] expq[$];
  int exp_frames = 0, exp_bytes = 0, exp_drops = 0;

  always #5 clk = ~clk;

  assign hdr_word = 32'hA5000000 | (32'(hdr_idx) * 32'h01010101);

  cpu_inject_framer i_cpu_inject_framer (
    .clk, .rst_n, .start, .len, .q_ready, .q_wmark, .pay_byte, .pay_valid,
    .pay_ready, .hdr_idx, .hdr_word, .ctl_we, .ctl_sof, .ctl_eof, .ctl_vld,
    .ctl_gap, .data_we, .wr_data, .busy, .rejected, .tx_frames, .tx_bytes, .drop_cnt);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] ctl_item(bit sof, bit eof, logic [1:0] vld);
    return {1'b1, 27'd0, sof, eof, vld, 4'd1};
  endfunction

  function automatic logic [35:0] dat_item(logic [31:0] d);
    return {1'b0, 3'd0, d};
  endfunction

  function automatic logic [7:0] fbyte(int f, int k);
    return 8'((k * 7 + f * 13 + 1) & 8'hff);
  endfunction

  // monitor: scoreboard pop and compare (R2..R7)
  always @(negedge clk) if (rst_n) begin
    logic [35:0] got;
    if (ctl_we || data_we) begin
      got = ctl_we ? {1'b1, 27'd0, ctl_sof, ctl_eof, ctl_vld, ctl_gap} : dat_item(wr_data);
      if (expq.size() == 0)
        chk(0, "R1/R7 unexpected write", longint'(got), 0);
      else begin
        logic [35:0] e;
        e = expq.pop_front();
        chk(got == e, got[35] ? "R2/R6 control write" : "R3/R4/R5/R7 data word",
            longint'(got), longint'(e));
      end
    end
  end

  task automatic send(input int f, input int n, input bit start_while_busy);
    int words;
    words = (n + 3) / 4;
    expq.push_back(ctl_item(1, 0, 2'd0));                       // R2
    for (int h = 0; h < 9; h++)
      expq.push_back(dat_item(32'hA5000000 | (32'(h) * 32'h01010101))); // R3
    for (int w = 0; w < words; w++) begin                      // R4
      logic [31:0] d;
      d = '0;
      for (int b = 0; b < 4; b++)
        if (w * 4 + b < n) d[b*8 +: 8] = fbyte(f, w * 4 + b);
      expq.push_back(dat_item(d));
    end
    for (int w = words; w < 15; w++) expq.push_back(dat_item('0)); // R5
    expq.push_back(ctl_item(0, 1, n < 60 ? 2'd0 : 2'(n % 4)));   // R6
    expq.push_back(dat_item('0));                               // R7
    len = 14'(n);
    start = 1;
    @(posedge clk); #1;
    start = start_while_busy;
    @(negedge clk);
    chk(busy == 1, "R9 busy after accept", busy, 1);
    for (int k = 0; k < n; k++) begin
      if (k % 5 == 3) begin
        pay_valid = 0;
        @(posedge clk); #1;
      end
      pay_byte = fbyte(f, k);
      pay_valid = 1;
      if (k == n - 1) start = 0;
      do @(negedge clk); while (!pay_ready);
      @(posedge clk); #1;
    end
    pay_valid = 0;
    start = 0;
    while (busy) @(posedge clk);
    #1;
    @(negedge clk);
    exp_frames++;
    exp_bytes += n;
    chk(expq.size() == 0, "R4/R5/R7 all writes seen", expq.size(), 0);
    chk(tx_frames == exp_frames, "R8 tx_frames", tx_frames, exp_frames);
    chk(tx_bytes == exp_bytes, "R8 tx_bytes", tx_bytes, exp_bytes);
    chk(!rejected, "R9 no reject while busy", rejected, 0);
  endtask

  task automatic refuse(input bit rdy, input bit wm);
    q_ready = rdy;
    q_wmark = wm;
    len = 14'd64;
    start = 1;
    @(posedge clk); #1;
    start = 0;
    @(negedge clk);
    exp_drops++;
    chk(rejected == 1, "R1 rejected pulse", rejected, 1);
    chk(!busy, "R1 not started", busy, 0);
    @(negedge clk);
    chk(rejected == 0, "R1 pulse one cycle", rejected, 0);
    chk(drop_cnt == exp_drops, "R1 drop_cnt", drop_cnt, exp_drops);
    q_ready = 1;
    q_wmark = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(tx_frames == 0 && tx_bytes == 0 && drop_cnt == 0, "R10 counters zero", tx_frames, 0);
    chk(!ctl_we && !data_we && !busy && !rejected && !pay_ready, "R10 idle outputs",
        {ctl_we, data_we, busy, rejected, pay_ready}, 0);
    @(posedge clk); #1;
    send(0, 1, 0);
    send(1, 3, 0);
    refuse(0, 0);
    send(2, 59, 0);
    send(3, 60, 0);
    refuse(1, 1);
    send(4, 61, 1);
    send(5, 66, 0);
    send(6, 100, 0);
    refuse(0, 1);
    send(7, 63, 0);
    chk(tx_frames == exp_frames, "R8 final frames", tx_frames, exp_frames);
    chk(drop_cnt == exp_drops, "R1 final drops", drop_cnt, exp_drops);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule